// File: doc/BRIEF.md
# Sector Hit Timestamp Stack

This block records the hits of one 42-pixel sector over a bunch train. The pixels are split into seven groups of six. An external sequencer drives a group address that visits 0, then groups 1 to 7, then returns to 0 within every bunch-crossing interval. On each clock edge where the address names a real group and that group has at least one pixel hit, the block stores a 22-bit record. The record holds the six-bit hit pattern, the three-bit group number and the 13-bit crossing timestamp.

Storage is a last-in, first-out stack of 19 entries. The stack pointer is the only record of how full the stack is. There is no hit counter. When the 19th record is written, the sector goes dead and ignores all later hits until the next train start. A hit that arrives while the sector is dead sets a sticky overflow flag. Overflow is therefore raised by the 20th attempted hit, not by the 19th write that fills the stack. Because no counter exists, the number of hits lost after overflow is not kept.

Readout is combinational and indexed from the top of the stack. Index 0 always returns the most recent record.

Top module: `sector_hit_stack`

## Requirements
- R1: A stored record reads as {pattern[21:16], group[15:13], timestamp[12:0]}. The pattern and timestamp are the values present on the clock edge that writes the record.
- R2: Readout is last-in, first-out. `rd_idx` 0 returns the newest record, and each higher index returns the next older one.
- R3: Group address 0 never writes a record, whatever the hit inputs are.
- R4: A nonzero group address with an all-zero six-bit pattern writes no record.
- R5: The 19th write fills the stack and raises `dead` in the following cycle, while `ovf` stays low.
- R6: A qualifying hit while `dead` is high sets `ovf` in the next cycle. `ovf` then stays set until train start.
- R7: While `dead` is high, no record is written and the stored contents stay unchanged.
- R8: `train_clr` synchronously clears the stack pointer, `ovf` and `dead`.
- R9: An `rd_idx` at or above `fill_ptr` gives `rd_valid` low and `rd_word` all zeros.
- R10: Group g (1 to 7) takes its pattern from `hit_bits[6*(g-1) +: 6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the group address sequence |
| train_clr | input | 1 | Synchronous train-start clear |
| grp_addr | input | 3 | Current group address. 0 means idle |
| hit_bits | input | 42 | Hit flags of all sector pixels, grouped by six |
| ts | input | 13 | Bunch-crossing timestamp |
| rd_idx | input | 5 | Readout index counted from the top of the stack |
| rd_word | output | 22 | Selected record, or zero when the index is out of range |
| rd_valid | output | 1 | High when `rd_idx` names a stored record |
| fill_ptr | output | 5 | Stack pointer, equal to the number of stored records |
| dead | output | 1 | Stack full. Hits are ignored |
| ovf | output | 1 | Sticky flag set by a hit arriving while full |

## Verification
The bench uses the default parameters: seven groups of six pixels, a 13-bit timestamp and a depth of 19. With these values, three crossings in which every group is hit reach the full-stack boundary in the middle of a crossing. The 19th write lands on group 5 of the third crossing and the first rejected hit lands on group 6. This lets the bench check fill and overflow on neighbouring cycles. The all-ones timestamp and the idle address phase are also covered.

// File: rtl/hitstk_pkg.sv
package hitstk_pkg;
   localparam int unsigned HS_PIX_DEF   = 6;
   localparam int unsigned HS_GRP_DEF   = 7;
   localparam int unsigned HS_TS_DEF    = 13;
   localparam int unsigned HS_DEPTH_DEF = 19;

   // Minimum bit count able to hold values 0..n-1 (at least one bit).
   function automatic int unsigned hs_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/hitstk_grp_sel.sv
module hitstk_grp_sel #(
   parameter int unsigned PIX  = 6,
   parameter int unsigned NGRP = 7,
   parameter int unsigned GA_W = 3
) (
   input  logic [NGRP*PIX-1:0] hits,
   input  logic [GA_W-1:0]     addr,
   output logic [PIX-1:0]      pattern,
   output logic                hit_any
);
   logic [PIX-1:0] lane [NGRP+1];

   // Lane 0 is the idle address and carries no pixels.
   assign lane[0] = '0;
   for (genvar g = 1; g <= NGRP; g++) begin : g_lane
      assign lane[g] = hits[(g-1)*PIX +: PIX];
   end

   always_comb begin
      pattern = '0;
      for (int g = 0; g <= NGRP; g++) begin
         if (addr == GA_W'(g)) pattern = lane[g];
      end
   end

   assign hit_any = |pattern;
endmodule

// File: rtl/hitstk_lifo.sv
module hitstk_lifo #(
   parameter int unsigned WORD_W = 22,
   parameter int unsigned DEPTH  = 19,
   parameter int unsigned PTR_W  = 5
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              push,
   input  logic [WORD_W-1:0] din,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [PTR_W-1:0]  ptr,
   output logic              full,
   output logic [WORD_W-1:0] rd_word,
   output logic              rd_valid
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_pos;
   logic              do_write;

   assign full     = (ptr == PTR_W'(DEPTH));
   assign do_write = push && !full;

   always_ff @(posedge clk) begin
      if (clr)           ptr <= '0;
      else if (do_write) ptr <= ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (do_write && !clr) mem[ptr] <= din;
   end

   assign rd_valid = (rd_idx < ptr);
   assign rd_pos   = ptr - PTR_W'(1) - rd_idx;
   assign rd_word  = rd_valid ? mem[rd_pos] : '0;
endmodule

// File: rtl/hitstk_ovf.sv
module hitstk_ovf (
   input  logic clk,
   input  logic clr,
   input  logic attempt,
   input  logic full,
   output logic ovf
);
   always_ff @(posedge clk) begin
      if (clr)                  ovf <= 1'b0;
      else if (attempt && full) ovf <= 1'b1;
   end
endmodule

// File: rtl/sector_hit_stack.sv
module sector_hit_stack
   import hitstk_pkg::*;
#(
   parameter int unsigned PIX   = HS_PIX_DEF,
   parameter int unsigned NGRP  = HS_GRP_DEF,
   parameter int unsigned TS_W  = HS_TS_DEF,
   parameter int unsigned DEPTH = HS_DEPTH_DEF,
   localparam int unsigned GA_W   = hs_bits(NGRP + 1),
   localparam int unsigned PTR_W  = hs_bits(DEPTH + 1),
   localparam int unsigned HITS_W = NGRP * PIX,
   localparam int unsigned WORD_W = PIX + GA_W + TS_W
) (
   input  logic              clk,
   input  logic              train_clr,
   input  logic [GA_W-1:0]   grp_addr,
   input  logic [HITS_W-1:0] hit_bits,
   input  logic [TS_W-1:0]   ts,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_word,
   output logic              rd_valid,
   output logic [PTR_W-1:0]  fill_ptr,
   output logic              dead,
   output logic              ovf
);
   if (PIX < 1)   begin : g_bad_pix   $error("PIX must be at least 1");   end
   if (NGRP < 1)  begin : g_bad_grp   $error("NGRP must be at least 1");  end
   if (TS_W < 1)  begin : g_bad_ts    $error("TS_W must be at least 1");  end
   if (DEPTH < 1) begin : g_bad_depth $error("DEPTH must be at least 1"); end

   logic [PIX-1:0]    pattern;
   logic              hit_any;
   logic              attempt;
   logic              full;
   logic [WORD_W-1:0] rec;

   hitstk_grp_sel #(.PIX(PIX), .NGRP(NGRP), .GA_W(GA_W)) i_sel (
      .hits    (hit_bits),
      .addr    (grp_addr),
      .pattern (pattern),
      .hit_any (hit_any)
   );

   assign attempt = hit_any && (grp_addr != '0);
   assign rec     = {pattern, grp_addr, ts};

   hitstk_lifo #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) i_lifo (
      .clk      (clk),
      .clr      (train_clr),
      .push     (attempt),
      .din      (rec),
      .rd_idx   (rd_idx),
      .ptr      (fill_ptr),
      .full     (full),
      .rd_word  (rd_word),
      .rd_valid (rd_valid)
   );

   hitstk_ovf i_ovf (
      .clk     (clk),
      .clr     (train_clr),
      .attempt (attempt),
      .full    (full),
      .ovf     (ovf)
   );

   assign dead = full;
endmodule

// File: rtl/hitstk_checker.sv
module hitstk_checker #(
   parameter int unsigned DEPTH = 19,
   parameter int unsigned PTR_W = 5,
   parameter int unsigned GA_W  = 3
) (
   input logic             clk,
   input logic             train_clr,
   input logic [GA_W-1:0]  grp_addr,
   input logic [PTR_W-1:0] fill_ptr,
   input logic             dead,
   input logic             ovf
);
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (train_clr) (grp_addr == '0) |=> (fill_ptr == $past(fill_ptr))); // R3
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (train_clr) 1'b1 |=> (fill_ptr == $past(fill_ptr) || fill_ptr == $past(fill_ptr) + PTR_W'(1))); // R2
   AST_PTR_BOUND: assert property (@(posedge clk) disable iff (train_clr) fill_ptr <= PTR_W'(DEPTH)); // R5
   AST_FILL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (train_clr) $rose(dead) |-> !ovf); // R5
   AST_OVERFLOW_NEEDS_DEAD: assert property (@(posedge clk) disable iff (train_clr) $rose(ovf) |-> $past(dead)); // R6
   AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (train_clr) ovf |=> ovf); // R6
   AST_DEAD_FROZEN: assert property (@(posedge clk) disable iff (train_clr) dead |=> (dead && $stable(fill_ptr))); // R7
   AST_TRAIN_CLEAR: assert property (@(posedge clk) train_clr |=> (fill_ptr == '0 && !ovf && !dead)); // R8
endmodule

bind sector_hit_stack hitstk_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W), .GA_W(GA_W)) i_chk (
   .clk       (clk),
   .train_clr (train_clr),
   .grp_addr  (grp_addr),
   .fill_ptr  (fill_ptr),
   .dead      (dead),
   .ovf       (ovf)
);

// File: tb/test_sector_hit_stack.sv
module test_sector_hit_stack;
   localparam int NG = 7, PX = 6, TW = 13, DP = 19;

   logic          clk = 1'b0;
   logic          train_clr;
   logic [2:0]    grp_addr;
   logic [41:0]   hit_bits;
   logic [12:0]   ts;
   logic [4:0]    rd_idx;
   logic [21:0]   rd_word;
   logic          rd_valid;
   logic [4:0]    fill_ptr;
   logic          dead;
   logic          ovf;

   int checks = 0;
   int errors = 0;
   logic [21:0] exp_q [$];
   bit          m_ovf;

   always #2 clk = ~clk;

   sector_hit_stack i_sector_hit_stack (
      .clk(clk), .train_clr(train_clr), .grp_addr(grp_addr), .hit_bits(hit_bits),
      .ts(ts), .rd_idx(rd_idx), .rd_word(rd_word), .rd_valid(rd_valid),
      .fill_ptr(fill_ptr), .dead(dead), .ovf(ovf)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [5:0] pat(input int g, input int seed);
      return 6'(((g * 11 + seed) % 63) + 1);
   endfunction

   function automatic logic [41:0] all_hits(input int seed);
      logic [41:0] h = '0;
      for (int g = 1; g <= NG; g++) h[(g-1)*PX +: PX] = pat(g, seed);
      return h;
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic clear_train();
      train_clr = 1'b1; grp_addr = '0; hit_bits = '0;
      tick(); tick();
      train_clr = 1'b0;
      exp_q.delete(); m_ovf = 0;
      chk("R8", "fill_ptr after clear", fill_ptr, 0);
      chk("R8", "ovf after clear", ovf, 0);
      chk("R8", "dead after clear", dead, 0);
   endtask

   // Driver: one bunch crossing, addresses 0..7; model pushes expected records.
   task automatic crossing(input logic [41:0] h, input logic [12:0] t);
      for (int g = 0; g <= NG; g++) begin
         logic [5:0] p;
         grp_addr = 3'(g); hit_bits = h; ts = t;
         p = (g == 0) ? 6'd0 : h[(g-1)*PX +: PX];
         if (g != 0 && p != 0) begin
            if (exp_q.size() < DP) exp_q.push_back({p, 3'(g), t});
            else m_ovf = 1;
         end
         tick();
         chk("R5", "fill_ptr", fill_ptr, exp_q.size());
         chk("R5", "dead", dead, exp_q.size() == DP);
         chk("R6", "ovf", ovf, m_ovf);
      end
      grp_addr = '0;
   endtask

   // Monitor: pops expected records newest first and compares readout.
   task automatic readout(input string req);
      logic [21:0] cp [$];
      int i = 0;
      cp = exp_q;
      while (cp.size() > 0) begin
         logic [21:0] e;
         e = cp.pop_back();
         rd_idx = 5'(i); #1;
         chk(req, "rd_valid", rd_valid, 1);
         chk(req, "rd_word", rd_word, e);
         i++;
      end
      rd_idx = 5'(exp_q.size()); #1;
      chk("R9", "rd_valid past top", rd_valid, 0);
      chk("R9", "rd_word past top", rd_word, 0);
      rd_idx = 5'd31; #1;
      chk("R9", "rd_word at max idx", rd_word, 0);
      rd_idx = '0;
   endtask

   initial begin
      int n;
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      train_clr = 1'b1; grp_addr = '0; hit_bits = '0; ts = '0; rd_idx = '0;
      clear_train();
      chk("R9", "rd_valid empty", rd_valid, 0);

      // R3: idle address with every pixel hit writes nothing
      hit_bits = '1; grp_addr = '0;
      tick(); tick(); tick();
      chk("R3", "fill_ptr idle addr", fill_ptr, 0);
      hit_bits = '0;

      // R10 / R1 / R2: selective groups, distinct patterns
      begin
         logic [41:0] h = '0;
         h[(2-1)*PX +: PX] = 6'b101001;
         h[(6-1)*PX +: PX] = 6'b010110;
         crossing(h, 13'd100);
      end
      crossing('0, 13'd101); // R4: no pattern, no write
      chk("R4", "fill_ptr after empty crossing", fill_ptr, 2);
      begin
         logic [41:0] h = '0;
         h[0 +: PX]         = 6'b000001;
         h[(7-1)*PX +: PX]  = 6'b100000;
         crossing(h, 13'h1FFF);
      end
      readout("R1");
      rd_idx = 5'd0; #1;
      chk("R2", "newest is group 7", rd_word, {6'b100000, 3'd7, 13'h1FFF});
      rd_idx = 5'd3; #1;
      chk("R10", "oldest is group 2", rd_word, {6'b101001, 3'd2, 13'd100});
      rd_idx = '0;

      // R8 mid-train clear, then fill to overflow
      clear_train();
      crossing(all_hits(1), 13'd10);
      crossing(all_hits(2), 13'd11);
      crossing(all_hits(3), 13'd12); // 19th write at group 5, overflow at group 6
      chk("R6", "ovf after rejected hit", ovf, 1);
      crossing(all_hits(4), 13'd13);
      chk("R7", "fill_ptr frozen", fill_ptr, DP);
      readout("R7");

      clear_train();
      chk("R8", "rd_valid after clear", rd_valid, 0);

      // R5: exactly 19 writes then quiet crossings: no overflow
      crossing(all_hits(5), 13'd20);
      crossing(all_hits(6), 13'd21);
      begin
         logic [41:0] h = '0;
         for (int g = 1; g <= 5; g++) h[(g-1)*PX +: PX] = pat(g, 7);
         crossing(h, 13'd22);
      end
      crossing('0, 13'd23);
      chk("R5", "dead at 19", dead, 1);
      chk("R5", "ovf stays low", ovf, 0);
      readout("R2");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule